// File: doc/BRIEF.md
# Center-Spread Modulation Profile Controller

This block is the digital control core of a center-spread clock modulator. It runs on the reference clock and produces a signed frequency-offset word that an analog synthesizer adds to its nominal frequency. The offset traces a triangle around zero, and one full triangle spans a fixed number of reference cycles. The depth of the triangle comes from a lookup indexed by two three-state select inputs and a sub-band code. The sub-band code tells the block which slice of the input frequency range the reference clock falls in.

Each three-state input arrives already resolved into a 2-bit code. A select or band code that is not allowed in the current band turns the modulation off and raises a flag. An enable input lets the offset glide back to zero and park there. When enable returns, the sweep restarts from its center.

Top module: `ssc_profile`

## Requirements
- R1: Select codes are 2'b00 low, 2'b01 middle, 2'b10 high and 2'b11 not allowed. Band codes 0..3 are the low-band sub-bands 50-60, 60-70, 70-80 and 80-100 MHz. Band codes 4..8 are the high-band sub-bands 100-120, 120-130, 130-140, 140-150 and 150-166 MHz. Band codes 9..15 are not allowed. During reset `offset` is 0, `invalid` is 0 and `spread_tenths` is 43. The period that starts at reset uses the middle/middle setting in band 0 whatever the inputs are.
- R2: Let s be `spread_tenths` and p the number of cycles since the period start, with PERIOD = 2332 and Q = 583. Then `offset` equals p*s for p <= Q, (2Q-p)*s for Q <= p <= 3Q, and (p-4Q)*s up to the period end, where it is back at 0. The period then repeats.
- R3: The offset peaks at +Q*s and bottoms at -Q*s. The peak-to-peak swing is therefore s*1166 LSB, centered on zero.
- R4: In the low band, (sel_a,sel_b) = (M,M), (M,L), (H,L), (L,L) and (L,M) give these spreads in tenths of a percent for sub-bands 0..3: 43/40/38/35, 39/36/34/31, 33/31/29/27, 29/26/25/22 and 27/25/24/21.
- R5: In the high band, (H,M), (L,H), (H,H) and (M,H) give these spreads for sub-bands 4..8: 30/27/26/26/25, 24/21/20/20/18, 15/14/13/13/12 and 13/11/11/11/10.
- R6: The inputs are sampled only on the edge that ends a period, or on a restart. `spread_tenths` changes on that edge, and a change of the inputs in mid-period has no effect on that period.
- R7: If the sampled setting is not allowed, `invalid` is 1, `spread_tenths` is 0 and `offset` stays 0 for that whole period. `invalid` clears at the first boundary that samples an allowed setting.
- R8: When `spread_en` is low, the phase stops and `offset` moves toward zero by s each cycle, then holds at 0. Once the ramp has begun, it completes even if enable returns.
- R9: When the offset is parked at 0 and `spread_en` is high, the next edge restarts the period at phase 0 and samples the inputs afresh.
- R10: From one cycle to the next, `offset` never changes by more than the spread value in force in the earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a | input | 2 | First three-state select code |
| sel_b | input | 2 | Second three-state select code |
| band | input | 4 | Input-frequency sub-band code |
| spread_en | input | 1 | High enables modulation |
| offset | output | OFS_W | Signed frequency-offset word |
| spread_tenths | output | 6 | Peak-to-peak spread in force, tenths of a percent |
| invalid | output | 1 | Sampled setting is not allowed |

## Verification
The properties assume that reset is held from time zero until the first edges have passed. They also assume that the select, band and enable inputs are synchronous to the reference clock, so the value seen at each edge is a clean code. The stimulus meets both conditions by asserting reset at time zero and changing inputs only on falling edges. It also moves inputs both inside a period and at its boundaries, so that the sampling rule is stressed. Codes outside the allowed sets are applied on purpose, because the block must tolerate any 2-bit or 4-bit value.

// File: rtl/ssc_profile.sv
module ssc_profile #(
  parameter int PERIOD = 2332,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              sel_a,
  input  logic [1:0]              sel_b,
  input  logic [3:0]              band,
  input  logic                    spread_en,
  output logic signed [OFS_W-1:0] offset,
  output logic [5:0]              spread_tenths,
  output logic                    invalid
);
  localparam int PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0] Q1   = PH_W'(PERIOD / 4);
  localparam logic [PH_W-1:0] Q3   = PH_W'(3 * (PERIOD / 4));
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  function automatic logic [6:0] pick4(input logic [3:0] b, input logic [5:0] v0, v1, v2, v3);
    case (b)
      4'd0: pick4 = {1'b1, v0};
      4'd1: pick4 = {1'b1, v1};
      4'd2: pick4 = {1'b1, v2};
      4'd3: pick4 = {1'b1, v3};
      default: pick4 = '0;
    endcase
  endfunction

  function automatic logic [6:0] pick5(input logic [3:0] b, input logic [5:0] v0, v1, v2, v3, v4);
    case (b)
      4'd4: pick5 = {1'b1, v0};
      4'd5: pick5 = {1'b1, v1};
      4'd6: pick5 = {1'b1, v2};
      4'd7: pick5 = {1'b1, v3};
      4'd8: pick5 = {1'b1, v4};
      default: pick5 = '0;
    endcase
  endfunction

  function automatic logic [6:0] lookup(input logic [1:0] a, input logic [1:0] b, input logic [3:0] bd);
    case ({a, b})
      4'b0101: lookup = pick4(bd, 6'd43, 6'd40, 6'd38, 6'd35);
      4'b0100: lookup = pick4(bd, 6'd39, 6'd36, 6'd34, 6'd31);
      4'b1000: lookup = pick4(bd, 6'd33, 6'd31, 6'd29, 6'd27);
      4'b0000: lookup = pick4(bd, 6'd29, 6'd26, 6'd25, 6'd22);
      4'b0001: lookup = pick4(bd, 6'd27, 6'd25, 6'd24, 6'd21);
      4'b1001: lookup = pick5(bd, 6'd30, 6'd27, 6'd26, 6'd26, 6'd25);
      4'b0010: lookup = pick5(bd, 6'd24, 6'd21, 6'd20, 6'd20, 6'd18);
      4'b1010: lookup = pick5(bd, 6'd15, 6'd14, 6'd13, 6'd13, 6'd12);
      4'b0110: lookup = pick5(bd, 6'd13, 6'd11, 6'd11, 6'd11, 6'd10);
      default: lookup = '0;
    endcase
  endfunction

  logic [PH_W-1:0]         ph;
  logic                    run;
  logic [6:0]              lk;
  logic [5:0]              ld_step;
  logic signed [OFS_W-1:0] sstep;
  logic signed [OFS_W-1:0] toz;
  logic                    rising;

  assign lk      = lookup(sel_a, sel_b, band);
  assign ld_step = lk[6] ? lk[5:0] : 6'd0;
  assign sstep   = {{(OFS_W-6){1'b0}}, spread_tenths};
  assign rising  = (ph < Q1) || (ph >= Q3);
  assign toz     = (offset == '0) ? offset : (offset[OFS_W-1] ? offset + sstep : offset - sstep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph            <= '0;
      run           <= 1'b1;
      offset        <= '0;
      spread_tenths <= 6'd43;
      invalid       <= 1'b0;
    end else if (run) begin
      if (!spread_en) begin
        run    <= 1'b0;
        offset <= toz;
      end else begin
        offset <= rising ? offset + sstep : offset - sstep;
        if (ph == LAST) begin
          ph            <= '0;
          spread_tenths <= ld_step;
          invalid       <= ~lk[6];
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end else if (offset != '0) begin
      offset <= toz;
    end else if (spread_en) begin
      run           <= 1'b1;
      ph            <= '0;
      spread_tenths <= ld_step;
      invalid       <= ~lk[6];
    end
  end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int PERIOD = 2332,
  parameter int OFS_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spread_en,
  input logic signed [OFS_W-1:0] offset,
  input logic [5:0]              spread_tenths,
  input logic                    invalid
);
  localparam int QTR = PERIOD / 4;

  // R10
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(offset) - int'($past(offset))) <= int'($past(spread_tenths))) &&
    ((int'($past(offset)) - int'(offset)) <= int'($past(spread_tenths))));

  // R3
  peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) <= int'(spread_tenths) * QTR) && (int'(offset) >= -(int'(spread_tenths) * QTR)));

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (offset == '0 && spread_tenths == 6'd0));

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spread_en && offset == '0) |=> offset == '0);

  // R6
  latch_center_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spread_tenths != $past(spread_tenths)) |-> offset == '0);
endmodule

bind ssc_profile ssc_profile_chk #(.PERIOD(PERIOD), .OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .spread_en(spread_en),
  .offset(offset), .spread_tenths(spread_tenths), .invalid(invalid)
);

// File: tb/test_ssc_profile.sv
module test_ssc_profile;
  localparam int Q = 583;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel_a = 2'b00;
  logic [1:0]  sel_b = 2'b00;
  logic [3:0]  band = 4'd3;
  logic        spread_en = 1'b1;
  logic signed [15:0] offset;
  logic [5:0]  spread_tenths;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  ssc_profile i_ssc_profile (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .band(band),
    .spread_en(spread_en), .offset(offset), .spread_tenths(spread_tenths), .invalid(invalid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_sel(input logic [1:0] a, input logic [1:0] b, input logic [3:0] bd);
    sel_a = a; sel_b = b; band = bd;
  endtask

  task automatic t_reset;
    step_n(3);
    chk("R1 reset offset", int'(offset), 0);
    chk("R1 reset spread", int'(spread_tenths), 43);
    chk("R1 reset invalid", int'(invalid), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_period;
    step_n(Q);
    chk("R1 R3 first peak", int'(offset), 43 * Q);
    step_n(Q);
    chk("R2 mid crossing", int'(offset), 0);
    step_n(Q);
    chk("R3 trough", int'(offset), -43 * Q);
    step_n(Q);
    chk("R2 period end", int'(offset), 0);
    chk("R6 latched at boundary", int'(spread_tenths), 22);
  endtask

  task automatic t_midchange;
    step_n(700);
    chk("R2 falling slope", int'(offset), 466 * 22);
    set_sel(2'b01, 2'b01, 4'd0);
    step_n(300);
    chk("R6 mid change ignored", int'(offset), 166 * 22);
    chk("R6 spread held", int'(spread_tenths), 22);
    step_n(1332);
    chk("R6 new spread", int'(spread_tenths), 43);
  endtask

  task automatic t_lookup(input string tag, input logic [1:0] a, input logic [1:0] b,
                          input logic [3:0] bd, input int exp);
    set_sel(a, b, bd);
    step_n(4 * Q);
    chk(tag, int'(spread_tenths), exp);
    step_n(Q);
    chk(tag, int'(offset), exp * Q);
    step_n(3 * Q);
    chk("R2 end", int'(offset), 0);
  endtask

  task automatic t_invalid;
    set_sel(2'b10, 2'b01, 4'd0);
    step_n(4 * Q);
    chk("R7 flag", int'(invalid), 1);
    chk("R7 spread zero", int'(spread_tenths), 0);
    step_n(Q);
    chk("R7 offset zero", int'(offset), 0);
    step_n(3 * Q);
    set_sel(2'b11, 2'b01, 4'd2);
    step_n(4 * Q);
    chk("R7 code 11", int'(invalid), 1);
    set_sel(2'b01, 2'b01, 4'd12);
    step_n(4 * Q);
    chk("R7 band 12", int'(invalid), 1);
    set_sel(2'b00, 2'b00, 4'd2);
    step_n(4 * Q);
    chk("R7 flag clears", int'(invalid), 0);
    chk("R4 (L,L) band2", int'(spread_tenths), 25);
  endtask

  task automatic t_disable;
    step_n(300);
    chk("R2 rising", int'(offset), 300 * 25);
    spread_en = 1'b0;
    step_n(1);
    chk("R8 ramp one step", int'(offset), 299 * 25);
    step_n(299);
    chk("R8 reaches zero", int'(offset), 0);
    set_sel(2'b10, 2'b00, 4'd1);
    step_n(50);
    chk("R8 holds zero", int'(offset), 0);
    spread_en = 1'b1;
    step_n(1);
    chk("R9 restart offset", int'(offset), 0);
    chk("R9 restart sample", int'(spread_tenths), 31);
    step_n(Q);
    chk("R9 peak after restart", int'(offset), 31 * Q);
  endtask

  task automatic t_disable_negative;
    step_n(917);
    chk("R2 negative region", int'(offset), -334 * 31);
    spread_en = 1'b0;
    step_n(100);
    chk("R8 ramp up to zero", int'(offset), -234 * 31);
    spread_en = 1'b1;
    step_n(233);
    chk("R8 ramp continues", int'(offset), -31);
    step_n(1);
    chk("R8 zero reached", int'(offset), 0);
    step_n(1);
    step_n(Q);
    chk("R9 peak after late restart", int'(offset), 31 * Q);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_period();
    t_midchange();
    t_lookup("R4 (M,L) band3", 2'b01, 2'b00, 4'd3, 31);
    t_lookup("R4 (L,M) band1", 2'b00, 2'b01, 4'd1, 25);
    t_lookup("R5 (H,M) band4", 2'b10, 2'b01, 4'd4, 30);
    t_lookup("R5 (M,H) band8", 2'b01, 2'b10, 4'd8, 10);
    t_lookup("R5 (H,H) band6", 2'b10, 2'b10, 4'd6, 13);
    t_invalid();
    t_disable();
    t_disable_negative();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule